// File: doc/BRIEF.md
# Per-Block Protection Lock Controller

This block holds the protection state of every erase block in a small flash-style array and answers whether a program or erase may proceed on a block. Each block has a protect flag and a lock flag. The write-protect input level acts as a third state bit that all blocks share. Software commands set protection, clear protection or lock a block. While write-protect is low, a locked block is held protected and ignores every command. While write-protect is high, a locked block behaves like an unlocked one, except that the lock flag stays set.

A locked block must get back its own protect setting when write-protect returns high. For this reason each block keeps a hidden saved copy of its protect bit. The copy is taken when the block is forced protected, which happens either when write-protect falls on a locked block or when the block is locked while write-protect is low. When write-protect rises, the copy is written back to the protect bit. Commands arrive as a single-cycle pulse carrying an opcode and a block index. A separate query index selects the block whose status drives the outputs, and the outputs follow the query index combinationally.

Top module: `prot_lock_ctl`

## Requirements
- R1: After reset every block reads protected and unlocked (qryProtected=1, qryLocked=0, qryAllow=0), whatever the write-protect level.
- R2: qryAllow is 1 exactly when the queried block's protect bit is 0. A query index at or above NUM_BLOCKS reads qryProtected=1, qryLocked=0, qryAllow=0.
- R3: With wpIn high, opcode 2'b00 sets the protect bit and opcode 2'b01 clears it, on locked and unlocked blocks alike. The result is visible on the query outputs after the next rising clock edge.
- R4: Opcode 2'b10 sets both lock and protect. This works for any block while wpIn is high, and for an unlocked block while wpIn is low. When the block is locked while wpIn is low, its protect bit as it was before the command is saved.
- R5: While wpIn is low, a locked block ignores all commands and stays locked and protected.
- R6: When wpIn falls, each locked block saves its protect bit and is forced protected. Unlocked blocks keep their state.
- R7: When wpIn rises, each locked block takes back its saved protect bit. Unlocked blocks keep their state.
- R8: The lock flag of a block is cleared only by reset.
- R9: A command with a block index at or above NUM_BLOCKS, or with opcode 2'b11, changes no block.
- R10: When a wpIn level change and a command fall in the same cycle, the level change is applied first and the command is then judged against the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wpIn | input | 1 | Write-protect level |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdOp | input | 2 | 00 protect, 01 unprotect, 10 lock, 11 no-op |
| cmdIdx | input | IDX_W | Target block of the command |
| qryIdx | input | IDX_W | Block whose status is reported |
| qryAllow | output | 1 | Program or erase permitted on the queried block |
| qryLocked | output | 1 | Lock flag of the queried block |
| qryProtected | output | 1 | Protect bit of the queried block |

## Verification
Commands and wpIn level changes take effect on the first rising edge at which they are present. The query outputs are combinational from the state registers and qryIdx, so each result can be read one cycle after its stimulus. The bench drives all inputs on the falling edge, lets a behavioural model apply the same rising edge, and compares the three outputs at the following falling edge. A command step sets the query index to its own target, so the updated state of that block is checked in the very next cycle.

// File: rtl/prot_lock_pkg.sv
package prot_lock_pkg;

  typedef enum logic [1:0] {
    OP_PROTECT   = 2'b00,
    OP_UNPROTECT = 2'b01,
    OP_LOCK      = 2'b10,
    OP_NONE      = 2'b11
  } protOp_e;

  // strobes from the control to the per-block state
  typedef struct packed {
    logic wpNow;    // write-protect level after this edge
    logic wpFall;
    logic wpRise;
    logic setProt;
    logic clrProt;
    logic setLock;
  } protStrobe_t;

endpackage

// File: rtl/prot_lock_ctrl.sv
module prot_lock_ctrl
  import prot_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wpIn,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [IDX_W-1:0] cmdIdx,
  output protStrobe_t      strb,
  output logic [IDX_W-1:0] tgtIdx
);

  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_BLOCKS);

  logic wpReg;
  logic cmdHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wpReg <= 1'b0;
    else       wpReg <= wpIn;
  end

  assign cmdHit = cmdValid && ({1'b0, cmdIdx} < LIMIT);

  always_comb begin
    strb.wpNow   = wpIn;
    strb.wpFall  = wpReg && !wpIn;
    strb.wpRise  = !wpReg && wpIn;
    strb.setProt = cmdHit && (cmdOp == OP_PROTECT);
    strb.clrProt = cmdHit && (cmdOp == OP_UNPROTECT);
    strb.setLock = cmdHit && (cmdOp == OP_LOCK);
  end

  assign tgtIdx = cmdIdx;

endmodule

// File: rtl/prot_lock_dpath.sv
module prot_lock_dpath
  import prot_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  protStrobe_t      strb,
  input  logic [IDX_W-1:0] tgtIdx,
  input  logic [IDX_W-1:0] qryIdx,
  output logic             qryAllow,
  output logic             qryLocked,
  output logic             qryProtected
);

  logic [NUM_BLOCKS-1:0] protVec;
  logic [NUM_BLOCKS-1:0] lockVec;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(b);

    logic protQ, lockQ, saveQ;
    logic protN, lockN, saveN;
    logic sel;

    assign sel = (tgtIdx == MY_IDX) && (strb.setProt || strb.clrProt || strb.setLock);

    always_comb begin
      protN = protQ;
      lockN = lockQ;
      saveN = saveQ;
      // level change first
      if (lockQ && strb.wpFall) begin
        saveN = protQ;
        protN = 1'b1;
      end
      if (lockQ && strb.wpRise) begin
        protN = saveQ;
      end
      // then the command, judged on the new level
      if (sel && (strb.wpNow || !lockQ)) begin
        if (strb.setProt) protN = 1'b1;
        if (strb.clrProt) protN = 1'b0;
        if (strb.setLock) begin
          if (!strb.wpNow) saveN = protN;
          lockN = 1'b1;
          protN = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        protQ <= 1'b1;
        lockQ <= 1'b0;
        saveQ <= 1'b1;
      end else begin
        protQ <= protN;
        lockQ <= lockN;
        saveQ <= saveN;
      end
    end

    assign protVec[b] = protQ;
    assign lockVec[b] = lockQ;
  end

  always_comb begin
    qryProtected = 1'b1;
    qryLocked    = 1'b0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (qryIdx == IDX_W'(i)) begin
        qryProtected = protVec[i];
        qryLocked    = lockVec[i];
      end
    end
    qryAllow = !qryProtected;
  end

endmodule

// File: rtl/prot_lock_ctl.sv
module prot_lock_ctl
  import prot_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wpIn,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [IDX_W-1:0] cmdIdx,
  input  logic [IDX_W-1:0] qryIdx,
  output logic             qryAllow,
  output logic             qryLocked,
  output logic             qryProtected
);

  protStrobe_t      strb;
  logic [IDX_W-1:0] tgtIdx;

  prot_lock_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wpIn     (wpIn),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdIdx   (cmdIdx),
    .strb     (strb),
    .tgtIdx   (tgtIdx)
  );

  prot_lock_dpath #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .tgtIdx       (tgtIdx),
    .qryIdx       (qryIdx),
    .qryAllow     (qryAllow),
    .qryLocked    (qryLocked),
    .qryProtected (qryProtected)
  );

endmodule

// File: rtl/prot_lock_ctl_chk.sv
module prot_lock_ctl_chk #(
  parameter int NUM_BLOCKS = 6,
  parameter int IDX_W      = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             wpIn,
  input logic             cmdValid,
  input logic [1:0]       cmdOp,
  input logic [IDX_W-1:0] cmdIdx,
  input logic [IDX_W-1:0] qryIdx,
  input logic             qryAllow,
  input logic             qryLocked,
  input logic             qryProtected
);

  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_BLOCKS);

  // R2: out-of-range query reads as protected and unlocked
  p_outrange_query_r2: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, qryIdx} >= LIMIT) |-> (!qryAllow && !qryLocked && qryProtected));

  // R3: protect with write-protect high takes effect next cycle
  p_protect_cmd_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cmdValid && cmdOp == 2'b00 && cmdIdx == qryIdx && wpIn) && $stable(qryIdx))
      |-> qryProtected);

  // R3: unprotect with write-protect high allows program/erase next cycle
  p_unprotect_cmd_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cmdValid && cmdOp == 2'b01 && cmdIdx == qryIdx && wpIn &&
           ({1'b0, cmdIdx} < LIMIT)) && $stable(qryIdx))
      |-> qryAllow);

  // R4: lock leaves the block locked and protected
  p_lock_cmd_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cmdValid && cmdOp == 2'b10 && cmdIdx == qryIdx &&
           ({1'b0, cmdIdx} < LIMIT)) && $stable(qryIdx))
      |-> (qryLocked && qryProtected));

  // R5/R6: a locked block under a low write-protect level is never writable
  p_locked_low_protected_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wpIn) && qryLocked) |-> (qryProtected && !qryAllow));

  // R8: the lock flag never clears outside reset
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(qryIdx) && $past(qryLocked)) |-> qryLocked);

endmodule

bind prot_lock_ctl prot_lock_ctl_chk #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wpIn         (wpIn),
  .cmdValid     (cmdValid),
  .cmdOp        (cmdOp),
  .cmdIdx       (cmdIdx),
  .qryIdx       (qryIdx),
  .qryAllow     (qryAllow),
  .qryLocked    (qryLocked),
  .qryProtected (qryProtected)
);

// File: tb/prot_lock_ctl_tb.sv
`timescale 1ns/1ps
module prot_lock_ctl_tb;

  localparam int NB = 6;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wpIn = 1'b1;
  logic          cmdValid = 1'b0;
  logic [1:0]    cmdOp = 2'b00;
  logic [IW-1:0] cmdIdx = '0;
  logic [IW-1:0] qryIdx = '0;
  logic          qryAllow, qryLocked, qryProtected;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  bit mProt [NB];
  bit mLock [NB];
  bit mSave [NB];
  bit mWp;

  always #2 clk = ~clk;

  prot_lock_ctl #(.NUM_BLOCKS(NB), .IDX_W(IW)) u_dut (
    .clk(clk), .rstN(rstN), .wpIn(wpIn), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIdx(cmdIdx), .qryIdx(qryIdx), .qryAllow(qryAllow),
    .qryLocked(qryLocked), .qryProtected(qryProtected)
  );

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    bit nw;
    int t;
    if (!rstN) begin
      for (int b = 0; b < NB; b++) begin
        mProt[b] = 1'b1; mLock[b] = 1'b0; mSave[b] = 1'b1;
      end
      mWp = 1'b0;
    end else begin
      nw = wpIn;
      for (int b = 0; b < NB; b++) begin
        if (mLock[b] && mWp && !nw) begin
          mSave[b] = mProt[b];
          mProt[b] = 1'b1;
        end else if (mLock[b] && !mWp && nw) begin
          mProt[b] = mSave[b];
        end
      end
      t = int'(cmdIdx);
      if (cmdValid && t < NB && cmdOp != 2'b11 && (nw || !mLock[t])) begin
        case (cmdOp)
          2'b00: mProt[t] = 1'b1;
          2'b01: mProt[t] = 1'b0;
          default: begin
            if (!nw) mSave[t] = mProt[t];
            mLock[t] = 1'b1;
            mProt[t] = 1'b1;
          end
        endcase
      end
      mWp = nw;
    end
  end

  task automatic compare(input int q);
    bit eA, eL, eP;
    if (q < NB) begin
      eP = mProt[q]; eL = mLock[q]; eA = !mProt[q];
    end else begin
      eP = 1'b1; eL = 1'b0; eA = 1'b0;
    end
    checks++;
    if (qryAllow !== eA || qryLocked !== eL || qryProtected !== eP) begin
      failures++;
      $display("FAIL %s block=%0d allow/locked/protected actual=%b%b%b expected=%b%b%b",
               curReq, q, qryAllow, qryLocked, qryProtected, eA, eL, eP);
    end
  endtask

  // called right after a falling edge: drive, let one rising edge pass, compare
  task automatic step(input bit v, input bit [1:0] op, input int idx, input int q);
    cmdValid = v;
    cmdOp    = op;
    cmdIdx   = IW'(idx);
    qryIdx   = IW'(q);
    @(negedge clk);
    compare(q);
  endtask

  task automatic look(input int q);
    step(1'b0, 2'b00, 0, q);
  endtask

  task automatic cmd(input bit [1:0] op, input int idx);
    step(1'b1, op, idx, idx);
  endtask

  initial begin
    rstN = 1'b0;
    wpIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    curReq = "R1";
    for (int q = 0; q < 8; q++) look(q);

    curReq = "R3";
    cmd(2'b01, 0); cmd(2'b01, 1); cmd(2'b01, 2); cmd(2'b00, 1);
    curReq = "R2";
    look(0); look(1); look(6); look(7);

    curReq = "R4";
    cmd(2'b10, 2);
    curReq = "R3";
    cmd(2'b01, 2); cmd(2'b00, 2); cmd(2'b01, 2);
    curReq = "R4";
    cmd(2'b10, 3);

    curReq = "R6";
    wpIn = 1'b0;
    look(2); look(3); look(0); look(1);

    curReq = "R5";
    cmd(2'b01, 2); cmd(2'b01, 3); cmd(2'b00, 2); cmd(2'b10, 3);
    curReq = "R4";
    cmd(2'b00, 0); cmd(2'b01, 0); cmd(2'b10, 4); cmd(2'b01, 5); cmd(2'b10, 5);

    curReq = "R9";
    step(1'b1, 2'b01, 6, 1);
    step(1'b1, 2'b10, 7, 0);
    step(1'b1, 2'b11, 1, 1);
    step(1'b1, 2'b11, 0, 0);

    curReq = "R7";
    wpIn = 1'b1;
    look(2); look(3); look(4); look(5); look(0); look(1);

    curReq = "R10";
    wpIn = 1'b0; cmd(2'b01, 2);
    wpIn = 1'b1; cmd(2'b00, 2);
    wpIn = 1'b0; cmd(2'b10, 0);
    wpIn = 1'b1; cmd(2'b01, 0);

    curReq = "R8";
    for (int k = 0; k < 20; k++) begin
      if (k % 5 == 0) wpIn = ~wpIn;
      cmd((k % 2 == 0) ? 2'b01 : 2'b00, 3);
      look(4);
    end

    curReq = "R2";
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 7) == 0) wpIn = ~wpIn;
      step(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
    end

    curReq = "R1";
    wpIn = 1'b0;
    rstN = 1'b0;
    look(0);
    rstN = 1'b1;
    for (int q = 0; q < 8; q++) look(q);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule